// File: doc/BRIEF.md
# Paged Address Translation Unit

This block is a small memory-management unit for an 8-bit CPU with a 16-bit logical address bus. It splits the logical space into sixteen pages of 4 KB. Each page is redirected through one of sixteen 8-bit mapping registers. Bits 15..12 of the CPU address pick the register, and the register's value comes out as the translated page number. The low six bits of that page number become physical address bits 17..12, which gives a 256 KB physical space. The 12-bit page offset passes through unchanged.

The mapping registers are written through a 16-byte window at the very top of logical memory. They cannot be read back. A read in that window is steered to the monitor ROM that lies underneath. A region code tells the system decoder where each access lands:

- ROM: the translated page has low nibble F and offset bit 11 is set.
- I/O: the translated page has low nibble E.
- RAM: any other page.

On reset every register holds its own index. The map is therefore the identity, so ROM and I/O can be reached before software programs the map.

Top module: `page_xlate`

## Requirements
- R1: After reset, register n holds n. With no write yet, page_o equals {4'b0000, addr_i[15:12]} for every logical page.
- R2: A cycle with cs_i=1, vma_i=1, rw_i=0 and addr_i[15:4]=12'hFFF writes wdata_i into register addr_i[3:0] at the rising clock edge. The new value appears on page_o from the next cycle on, whenever addr_i[15:12] selects that register.
- R3: No register changes when any one of these holds: vma_i=0, cs_i=0, rw_i=1, or addr_i[15:4] is not 12'hFFF.
- R4: page_o is the content of register addr_i[15:12] in the same cycle, with no clock delay.
- R5: phys_addr_o[17:12] equals page_o[5:0], and phys_addr_o[11:0] equals addr_i[11:0].
- R6: Outside the window, region_o is 2 (ROM) when page_o[3:0]=4'hF and addr_i[11]=1.
- R7: Outside the window, region_o is 1 (I/O) when page_o[3:0]=4'hE, whatever the value of addr_i[11].
- R8: Outside the window, region_o is 0 (RAM) in every other case, including page_o[3:0]=4'hF with addr_i[11]=0.
- R9: A read (rw_i=1) with addr_i[15:4]=12'hFFF gives region_o=2 (ROM) whatever the map holds. Register contents are never returned, and the read changes no register.
- R10: A write (rw_i=0) with addr_i[15:4]=12'hFFF gives region_o=3 (register window), so that no memory device beneath the window is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | CPU clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Register window select from the system decoder |
| vma_i | input | 1 | CPU marks the cycle as a valid memory access |
| rw_i | input | 1 | 1 = read, 0 = write |
| addr_i | input | 16 | Logical CPU address |
| wdata_i | input | 8 | CPU write data |
| page_o | output | 8 | Translated page number (register contents) |
| phys_addr_o | output | 18 | Physical address: {page_o[5:0], addr_i[11:0]} |
| region_o | output | 2 | 0 RAM, 1 I/O, 2 ROM, 3 register window write |

## Verification
page_o, phys_addr_o and region_o follow the address in the same cycle. The bench therefore drives each new address just after the falling edge and compares all three outputs a short settle delay later, before the next rising edge. A register write lands on the rising edge that closes the write cycle. The reference model updates its page table only after that edge's comparison, so the new mapping is expected from the next cycle on and not before. Ignored writes are confirmed by translating the affected page in a later cycle and seeing the old value.

// File: rtl/page_xlate_pkg.sv
package page_xlate_pkg;
  localparam int unsigned NIB_W = 4;
  localparam logic [NIB_W-1:0] ROM_NIB = 4'hF;
  localparam logic [NIB_W-1:0] IO_NIB  = 4'hE;

  typedef enum logic [1:0] {
    REGION_RAM = 2'd0,
    REGION_IO  = 2'd1,
    REGION_ROM = 2'd2,
    REGION_REG = 2'd3
  } region_e;
endpackage

// File: rtl/page_regfile.sv
module page_regfile #(
  parameter int unsigned NUM_PAGES = 16,
  parameter int unsigned DATA_W    = 8,
  localparam int unsigned IDX_W    = $clog2(NUM_PAGES)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             wr_en_i,
  input  logic [IDX_W-1:0]                 wr_idx_i,
  input  logic [DATA_W-1:0]                wr_data_i,
  output logic [NUM_PAGES-1:0][DATA_W-1:0] page_q_o
);
  for (genvar g = 0; g < NUM_PAGES; g++) begin : g_reg
    // identity map at reset
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        page_q_o[g] <= DATA_W'(g);
      else if (wr_en_i && (wr_idx_i == IDX_W'(g)))
        page_q_o[g] <= wr_data_i;
    end
  end
endmodule

// File: rtl/page_lookup.sv
module page_lookup #(
  parameter int unsigned NUM_PAGES = 16,
  parameter int unsigned DATA_W    = 8,
  localparam int unsigned IDX_W    = $clog2(NUM_PAGES)
) (
  input  logic [NUM_PAGES-1:0][DATA_W-1:0] page_q_i,
  input  logic [IDX_W-1:0]                 idx_i,
  output logic [DATA_W-1:0]                page_o
);
  always_comb page_o = page_q_i[idx_i];
endmodule

// File: rtl/region_decode.sv
module region_decode
  import page_xlate_pkg::*;
(
  input  logic [NIB_W-1:0] nib_i,
  input  logic             off_msb_i,
  input  logic             win_i,
  input  logic             rw_i,
  output region_e          region_o
);
  always_comb begin
    if (win_i)
      region_o = rw_i ? REGION_ROM : REGION_REG;
    else if (nib_i == ROM_NIB && off_msb_i)
      region_o = REGION_ROM;
    else if (nib_i == IO_NIB)
      region_o = REGION_IO;
    else
      region_o = REGION_RAM;
  end
endmodule

// File: rtl/page_xlate.sv
module page_xlate
  import page_xlate_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned NUM_PAGES   = 16,
  parameter int unsigned REG_W       = 8,
  parameter int unsigned PHYS_PAGE_W = 6,
  localparam int unsigned IDX_W      = $clog2(NUM_PAGES),
  localparam int unsigned OFF_W      = ADDR_W - IDX_W,
  localparam int unsigned PHYS_W     = PHYS_PAGE_W + OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              vma_i,
  input  logic              rw_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  page_o,
  output logic [PHYS_W-1:0] phys_addr_o,
  output logic [1:0]        region_o
);
  logic [NUM_PAGES-1:0][REG_W-1:0] page_q;
  logic                            win;
  logic                            wr_en;
  region_e                         region;

  // window = top NUM_PAGES bytes of logical space
  assign win   = &addr_i[ADDR_W-1:IDX_W];
  assign wr_en = cs_i & vma_i & ~rw_i & win;

  page_regfile #(.NUM_PAGES(NUM_PAGES), .DATA_W(REG_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_idx_i  (addr_i[IDX_W-1:0]),
    .wr_data_i (wdata_i),
    .page_q_o  (page_q)
  );

  page_lookup #(.NUM_PAGES(NUM_PAGES), .DATA_W(REG_W)) u_lookup (
    .page_q_i (page_q),
    .idx_i    (addr_i[ADDR_W-1:OFF_W]),
    .page_o   (page_o)
  );

  region_decode u_region (
    .nib_i     (page_o[NIB_W-1:0]),
    .off_msb_i (addr_i[OFF_W-1]),
    .win_i     (win),
    .rw_i      (rw_i),
    .region_o  (region)
  );

  assign phys_addr_o = {page_o[PHYS_PAGE_W-1:0], addr_i[OFF_W-1:0]};
  assign region_o    = region;
endmodule

// File: rtl/page_xlate_chk.sv
module page_xlate_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cs_i,
  input logic        vma_i,
  input logic        rw_i,
  input logic [15:0] addr_i,
  input logic [7:0]  wdata_i,
  input logic [7:0]  page_o,
  input logic [17:0] phys_addr_o,
  input logic [1:0]  region_o
);
  logic past_ok;
  logic in_win;
  logic do_wr;
  assign in_win = (addr_i[15:4] == 12'hFFF);
  assign do_wr  = cs_i & vma_i & ~rw_i & in_win;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;

  p_reset_map_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !past_ok |-> page_o == {4'b0000, addr_i[15:12]});

  p_write_lands_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(do_wr) && addr_i[15:12] == $past(addr_i[3:0]))
      |-> page_o == $past(wdata_i));

  p_no_write_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !$past(do_wr) && $stable(addr_i[15:12])) |-> $stable(page_o));

  p_phys_page_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phys_addr_o[17:12] == page_o[5:0] && phys_addr_o[11:0] == addr_i[11:0]);

  p_io_region_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_win && page_o[3:0] == 4'hE) |-> region_o == 2'd1);

  p_win_read_rom_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_win && rw_i) |-> region_o == 2'd2);

  p_win_write_reg_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_win && !rw_i) |-> region_o == 2'd3);
endmodule

bind page_xlate page_xlate_chk u_chk (.*);

// File: tb/page_xlate_tb.sv
module page_xlate_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cs_i = 1'b0, vma_i = 1'b0, rw_i = 1'b1;
  logic [15:0] addr_i = 16'h0000;
  logic [7:0]  wdata_i = 8'h00;
  logic [7:0]  page_o;
  logic [17:0] phys_addr_o;
  logic [1:0]  region_o;

  int checks = 0;
  int errors = 0;
  int model [16];
  bit done = 0;

  always #5 clk_i = ~clk_i;

  page_xlate u_dut (.*);

  function automatic int exp_region(logic rw, logic [15:0] a, int pg);
    if (a[15:4] == 12'hFFF) return rw ? 2 : 3;
    if ((pg & 15) == 15 && a[11]) return 2;
    if ((pg & 15) == 14) return 1;
    return 0;
  endfunction

  function automatic string region_tag(logic rw, logic [15:0] a, int pg);
    if (a[15:4] == 12'hFFF) return rw ? "R9" : "R10";
    if ((pg & 15) == 15 && a[11]) return "R6";
    if ((pg & 15) == 14) return "R7";
    return "R8";
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // one bus cycle: drive after falling edge, compare, then let the rising edge act
  task automatic cyc(logic v, logic c, logic rw, logic [15:0] a, logic [7:0] d, string ptag);
    int pg;
    @(negedge clk_i);
    vma_i = v; cs_i = c; rw_i = rw; addr_i = a; wdata_i = d;
    #2;
    pg = model[a[15:12]];
    check(page_o == 8'(pg), ptag, page_o, pg);
    check(phys_addr_o == {6'(pg), a[11:0]}, "R5", phys_addr_o, {6'(pg), a[11:0]});
    check(region_o == 2'(exp_region(rw, a, pg)), region_tag(rw, a, pg),
          region_o, exp_region(rw, a, pg));
    @(posedge clk_i);
    if (v && c && !rw && a[15:4] == 12'hFFF) model[a[3:0]] = int'(d);
  endtask

  task automatic wr(logic [3:0] idx, logic [7:0] d);
    cyc(1, 1, 0, {12'hFFF, idx}, d, "R2");
  endtask

  task automatic rd(logic [15:0] a, string tag);
    cyc(1, 0, 1, a, 8'h00, tag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed = 32'h1234_5678;
    for (int i = 0; i < 16; i++) model[i] = i;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1: identity map straight after reset, both halves of each page
    for (int p = 0; p < 16; p++) rd({4'(p), 12'h123}, "R1");
    for (int p = 0; p < 15; p++) rd({4'(p), 12'h9AB}, "R1");
    rd(16'hF800, "R6");
    rd(16'hF7FF, "R8");
    rd(16'hE004, "R7");

    // R2/R4: remap a few pages and read through them
    wr(4'h0, 8'h25);
    rd(16'h0456, "R2");
    wr(4'h3, 8'hFE);
    rd(16'h3000, "R7");
    rd(16'h3FFF, "R4");
    wr(4'h5, 8'h0F);
    rd(16'h5800, "R6");
    rd(16'h57FF, "R8");
    wr(4'h6, 8'h3F);
    rd(16'h6C00, "R5");

    // R3: writes that must be ignored
    cyc(0, 1, 0, 16'hFFF1, 8'h77, "R3");
    rd(16'h1234, "R3");
    cyc(1, 0, 0, 16'hFFF1, 8'h77, "R3");
    rd(16'h1234, "R3");
    cyc(1, 1, 0, 16'hFFE1, 8'h77, "R3");
    rd(16'h1234, "R3");
    cyc(1, 1, 1, 16'hFFF1, 8'h77, "R3");
    rd(16'h1234, "R3");

    // R9: reads in the window go to ROM even when page F is remapped
    wr(4'hF, 8'h02);
    for (int k = 0; k < 16; k++) rd({12'hFFF, 4'(k)}, "R9");
    rd(16'hF900, "R9");
    wr(4'hF, 8'h0F);
    rd(16'hFFF0, "R9");

    // R10: window writes with cs low still flag the register region
    cyc(1, 0, 0, 16'hFFF8, 8'h11, "R10");
    rd(16'h8000, "R10");

    // back-to-back writes then a pseudo-random sweep
    for (int k = 0; k < 16; k++) wr(4'(k), 8'(k * 17 + 3));
    for (int n = 0; n < 400; n++) begin
      logic [15:0] a;
      logic [2:0]  op;
      seed = seed * 1103515245 + 12345;
      a  = seed[31:16];
      op = seed[10:8];
      if (op == 0)      cyc(1, 1, 0, {12'hFFF, a[3:0]}, a[11:4], "R2");
      else if (op == 1) cyc(seed[5], seed[6], seed[7], a, a[7:0], "R3");
      else              rd(a, "R4");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule